// File: doc/BRIEF.md
# CAN Bit Timing Unit

This unit turns the system clock into time quanta and steps each nominal bit through three phases. Each bit has one quantum of synchronisation, then a first timing segment that covers propagation and phase 1, then a second phase segment. It raises a strobe at the sample point and latches the bus value there, using either one sample or a two-of-three vote. At the end of each bit it raises a strobe that marks where the next transmit bit starts. Falling bus edges (recessive to dominant) realign the bit. A hard sync applies while the frame logic reports the bus idle. A resynchronisation limited by a jump width applies during a frame.

Timing values are written into a shadow set through two byte-wide registers. Writes are taken only while the software-init flag is set and the controller is not bus-off. The shadow set is copied into the active set when software clears that flag. A guard clears the flag, without a copy, when both segment fields in the shadow set are zero.

Top module: `can_bt_timing`

## Requirements
- R1: After reset, swinit_o is 1, sample_o and tx_point_o are 0 and rx_bit_o is 1. The active and shadow sets hold prescaler field 0, jump-width field 0, segment-1 field 3, segment-2 field 2 and single sampling, so one bit lasts 8 clocks.
- R2: tq_tick_o pulses once every (P+1) clocks, where P is bits [5:0] of register 0 in the active set.
- R3: A bit lasts 1 + T1 + T2 quanta. T1 is bits [3:0] of register 1 plus 1, and T2 is bits [6:4] of register 1 plus 1. A field value of 0 gives a segment of 2 quanta.
- R4: sample_o pulses on the tick that ends the last quantum of the (possibly lengthened) first segment. rx_bit_o takes the sampled bus value one clock later.
- R5: tx_point_o pulses on the tick that ends the last quantum of a bit, so the next quantum is the sync quantum.
- R6: When bit 7 of register 1 is 1, rx_bit_o takes the majority of the bus values seen at the last three ticks up to and including the sample tick. Otherwise it takes the value at the sample tick.
- R7: A write (cfg_wr_i, with cfg_sel_i 0 selecting register 0 and 1 selecting register 1) changes the shadow set only while swinit_o is 1 and bus_off_i is 0. Any other write is ignored.
- R8: The shadow set is copied into the active set only on a software write of 0 to software-init while it is 1. The copy also restarts the prescaler and returns the bit to its sync quantum.
- R9: While swinit_o is 1 and the segment-1 and segment-2 shadow fields are both zero, swinit_o clears on the next clock and no copy takes place. A register write made in that same clock is still accepted.
- R10: An edge is a tick where rx_i is 0 and the value at the previous tick was 1. An edge while bus_idle_i is 1 is a hard sync: the quantum that just ended counts as sync, and the next quantum is the first of segment 1. No sample or transmit strobe occurs on that tick.
- R11: An edge in quantum i of segment 1 (i ≥ 1), with the bus not idle, lengthens segment 1 by min(i, J) quanta. J is bits [7:6] of register 0 plus 1.
- R12: An edge in segment 2 with r quanta left after the current one ends the bit on that tick when r ≤ J. Otherwise it shortens segment 2 by J quanta.
- R13: At most one resynchronisation or hard sync acts per bit. Edges in the sync quantum have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Timing register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 prescaler/jump width, 1 segments/sampling |
| cfg_wdata_i | input | 8 | Write data |
| swinit_wr_i | input | 1 | Software-init write strobe |
| swinit_wdata_i | input | 1 | New software-init value |
| bus_off_i | input | 1 | Controller is bus-off |
| bus_idle_i | input | 1 | Bus idle, enables hard sync |
| rx_i | input | 1 | Bus level, 1 = recessive |
| swinit_o | output | 1 | Software-init flag |
| tq_tick_o | output | 1 | Time-quantum tick |
| sample_o | output | 1 | Sample point strobe |
| rx_bit_o | output | 1 | Last sampled bit |
| tx_point_o | output | 1 | Bit end / transmit point strobe |

## Verification
A constant recessive bus gives clean bit periods. These show the prescaler and segment arithmetic, including the zero-field minimum, apart from any edge handling. A bus that toggles at random with the idle flag switching between phases produces edges at every bit position. Those edges separate hard sync from late-edge lengthening, early-edge shortening and the one-per-bit limit. Glitchy data with three-sample voting on shows majority from single sampling. Writes made with software-init clear, with bus-off raised, and on the cycle the guard fires each show whether the shadow set was truly written, because the bit period that follows the next copy reveals it.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int BRP_W = 6;
  localparam int SJW_W = 2;
  localparam int TS1_W = 4;
  localparam int TS2_W = 3;
  localparam int CFG_W = BRP_W + SJW_W;
  localparam int POS_W = $clog2((1 << TS1_W) + (1 << SJW_W) + (1 << TS2_W) + 1);

  typedef struct packed {
    logic [BRP_W-1:0] brp;
    logic [SJW_W-1:0] sjw;
    logic [TS1_W-1:0] ts1;
    logic [TS2_W-1:0] ts2;
    logic             triple;
  } bt_cfg_t;

  localparam bt_cfg_t CFG_RST = '{brp: '0, sjw: '0, ts1: TS1_W'(3), ts2: TS2_W'(2), triple: 1'b0};
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg import can_bt_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic             cfg_sel_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             swinit_wr_i,
  input  logic             swinit_wdata_i,
  input  logic             bus_off_i,
  output logic             swinit_o,
  output logic             guard_o,
  output logic             load_o,
  output bt_cfg_t          act_o
);
  bt_cfg_t shd_q, act_q;
  logic    sw_q, wr_ok;

  always_comb begin
    guard_o = sw_q & (shd_q.ts1 == '0) & (shd_q.ts2 == '0);
    wr_ok   = cfg_wr_i & sw_q & ~bus_off_i;
    load_o  = sw_q & ~guard_o & swinit_wr_i & ~swinit_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= 1'b1;
      shd_q <= CFG_RST;
      act_q <= CFG_RST;
    end else begin
      if (guard_o)          sw_q <= 1'b0;
      else if (swinit_wr_i) sw_q <= swinit_wdata_i;
      if (load_o) act_q <= shd_q;
      if (wr_ok) begin
        if (!cfg_sel_i) {shd_q.sjw, shd_q.brp} <= cfg_wdata_i;
        else {shd_q.triple, shd_q.ts2, shd_q.ts1} <= cfg_wdata_i[TS1_W+TS2_W:0];
      end
    end
  end

  assign swinit_o = sw_q;
  assign act_o    = act_q;
endmodule

// File: rtl/can_bt_presc.sv
module can_bt_presc #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (restart_i || tick_o)  cnt_q <= '0;
    else                           cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq import can_bt_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic             rx_i,
  input  logic             idle_i,
  input  logic [TS1_W-1:0] ts1_i,
  input  logic [TS2_W-1:0] ts2_i,
  input  logic [SJW_W-1:0] sjw_i,
  input  logic             triple_i,
  output logic             sample_o,
  output logic             tx_point_o,
  output logic             rx_bit_o,
  output logic             hard_o,
  output logic [POS_W-1:0] pos_o
);
  typedef logic [POS_W-1:0] pos_t;

  pos_t t1_len, t2_len, sjw_len, t1_end, bit_end, remain, adj;
  pos_t pos_q, ext_q, shr_q;
  logic used_q, rx_bit_q;
  logic [1:0] hist_q;
  logic edge_s, late, early, quick_end, maj;

  always_comb begin
    t1_len    = (ts1_i == '0) ? pos_t'(2) : pos_t'(ts1_i) + pos_t'(1);
    t2_len    = (ts2_i == '0) ? pos_t'(2) : pos_t'(ts2_i) + pos_t'(1);
    sjw_len   = pos_t'(sjw_i) + pos_t'(1);
    t1_end    = t1_len + ext_q;
    bit_end   = t1_end + t2_len - shr_q;
    remain    = bit_end - pos_q;
    adj       = (pos_q < sjw_len) ? pos_q : sjw_len;
    edge_s    = tick_i & hist_q[0] & ~rx_i;
    hard_o    = edge_s & idle_i;
    late      = edge_s & ~idle_i & ~used_q & (pos_q != '0) & (pos_q <= t1_end);
    early     = edge_s & ~idle_i & ~used_q & (pos_q > t1_end);
    quick_end = early & (remain <= sjw_len);
    sample_o  = tick_i & ~hard_o & ~late & (pos_q == t1_end);
    tx_point_o = tick_i & ~hard_o & (quick_end | (~early & (pos_q == bit_end)));
    maj       = (hist_q[1] & hist_q[0]) | (hist_q[1] & rx_i) | (hist_q[0] & rx_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      ext_q    <= '0;
      shr_q    <= '0;
      used_q   <= 1'b0;
      hist_q   <= 2'b11;
      rx_bit_q <= 1'b1;
    end else begin
      if (tick_i)   hist_q   <= {hist_q[0], rx_i};
      if (sample_o) rx_bit_q <= triple_i ? maj : rx_i;
      if (restart_i) begin
        pos_q  <= '0;
        ext_q  <= '0;
        shr_q  <= '0;
        used_q <= 1'b0;
      end else if (tick_i) begin
        if (hard_o) begin
          pos_q  <= pos_t'(1);
          ext_q  <= '0;
          shr_q  <= '0;
          used_q <= 1'b1;
        end else if (tx_point_o) begin
          pos_q  <= '0;
          ext_q  <= '0;
          shr_q  <= '0;
          used_q <= 1'b0;
        end else begin
          pos_q <= pos_q + pos_t'(1);
          if (late) begin
            ext_q  <= ext_q + adj;
            used_q <= 1'b1;
          end
          if (early) begin
            shr_q  <= sjw_len;
            used_q <= 1'b1;
          end
        end
      end
    end
  end

  assign rx_bit_o = rx_bit_q;
  assign pos_o    = pos_q;
endmodule

// File: rtl/can_bt_timing.sv
module can_bt_timing import can_bt_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic             cfg_sel_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             swinit_wr_i,
  input  logic             swinit_wdata_i,
  input  logic             bus_off_i,
  input  logic             bus_idle_i,
  input  logic             rx_i,
  output logic             swinit_o,
  output logic             tq_tick_o,
  output logic             sample_o,
  output logic             rx_bit_o,
  output logic             tx_point_o
);
  bt_cfg_t          act;
  logic             guard, load, hard;
  logic [POS_W-1:0] pos;

  can_bt_cfg i_cfg (
    .clk_i, .rst_ni, .cfg_wr_i, .cfg_sel_i, .cfg_wdata_i,
    .swinit_wr_i, .swinit_wdata_i, .bus_off_i,
    .swinit_o, .guard_o(guard), .load_o(load), .act_o(act)
  );

  can_bt_presc #(.W(BRP_W)) i_presc (
    .clk_i, .rst_ni, .restart_i(load), .div_i(act.brp), .tick_o(tq_tick_o)
  );

  can_bt_seq i_seq (
    .clk_i, .rst_ni, .restart_i(load), .tick_i(tq_tick_o), .rx_i, .idle_i(bus_idle_i),
    .ts1_i(act.ts1), .ts2_i(act.ts2), .sjw_i(act.sjw), .triple_i(act.triple),
    .sample_o, .tx_point_o, .rx_bit_o, .hard_o(hard), .pos_o(pos)
  );
endmodule

// File: rtl/can_bt_chk.sv
module can_bt_chk import can_bt_pkg::*; (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             sample_i,
  input logic             tx_point_i,
  input logic             swinit_i,
  input logic             guard_i,
  input logic             load_i,
  input logic             hard_i,
  input logic [POS_W-1:0] pos_i,
  input logic [BRP_W-1:0] brp_i
);
  a_r2_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && brp_i != '0 && !load_i) |=> !tick_i);
  a_r4_sample_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> tick_i);
  a_r5_txpt_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_point_i |-> tick_i);
  a_r4_sample_not_txpt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_i && tx_point_i));
  a_r9_guard_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    guard_i |=> !swinit_i);
  a_r10_hard_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hard_i && !load_i) |=> (pos_i == POS_W'(1)));
endmodule

bind can_bt_timing can_bt_chk i_can_bt_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tq_tick_o), .sample_i(sample_o),
  .tx_point_i(tx_point_o), .swinit_i(swinit_o), .guard_i(guard), .load_i(load),
  .hard_i(hard), .pos_i(pos), .brp_i(act.brp)
);

// File: tb/test_can_bt_timing.sv
module test_can_bt_timing;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_sel = 0, sw_wr = 0, sw_wd = 0, bus_off = 0, idle = 0, rx = 1;
  logic [7:0] cfg_d = 8'h00;
  logic swinit, tick, sample, rx_bit, txp;
  int n_chk = 0, n_fail = 0, cyc = 0;

  can_bt_timing i_can_bt_timing (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_d),
    .swinit_wr_i(sw_wr), .swinit_wdata_i(sw_wd), .bus_off_i(bus_off), .bus_idle_i(idle),
    .rx_i(rx), .swinit_o(swinit), .tq_tick_o(tick), .sample_o(sample), .rx_bit_o(rx_bit),
    .tx_point_o(txp)
  );

  always #10 clk = ~clk;  // 50 MHz

  // Reference model state
  int m_cnt, m_pos, m_ext, m_shr;
  bit m_used, m_h0, m_h1, m_rxbit, m_sw;
  int s_brp, s_sjw, s_t1, s_t2, a_brp, a_sjw, a_t1, a_t2;
  bit s_tri, a_tri;
  bit e_tick, e_sample, e_txp, e_hard, e_late, e_early, e_maj;
  int e_adj, e_sjw;

  task automatic model_eval();
    int t1, t2, t1e, endb, rem;
    bit edg;
    t1 = (a_t1 == 0) ? 2 : a_t1 + 1;
    t2 = (a_t2 == 0) ? 2 : a_t2 + 1;
    e_sjw = a_sjw + 1;
    e_tick = (m_cnt == a_brp);
    edg = e_tick && m_h0 && (rx == 1'b0);
    e_hard = edg && idle;
    t1e = t1 + m_ext;
    endb = t1e + t2 - m_shr;
    rem = endb - m_pos;
    e_late = edg && !idle && !m_used && m_pos >= 1 && m_pos <= t1e;
    e_early = edg && !idle && !m_used && m_pos > t1e;
    e_adj = (m_pos < e_sjw) ? m_pos : e_sjw;
    e_sample = e_tick && !e_hard && !e_late && m_pos == t1e;
    e_txp = e_tick && !e_hard && ((e_early && rem <= e_sjw) || (!e_early && m_pos == endb));
    e_maj = (int'(m_h1) + int'(m_h0) + int'(rx)) >= 2;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pos = 0; m_ext = 0; m_shr = 0; m_used = 0;
      m_h0 = 1; m_h1 = 1; m_rxbit = 1; m_sw = 1;
      s_brp = 0; s_sjw = 0; s_t1 = 3; s_t2 = 2; s_tri = 0;
      a_brp = 0; a_sjw = 0; a_t1 = 3; a_t2 = 2; a_tri = 0;
    end else begin
      bit guard, load, wr;
      model_eval();
      guard = m_sw && s_t1 == 0 && s_t2 == 0;
      load = m_sw && !guard && sw_wr && !sw_wd;
      wr = cfg_wr && m_sw && !bus_off;
      if (e_sample) m_rxbit = a_tri ? e_maj : rx;
      if (e_tick) begin m_h1 = m_h0; m_h0 = rx; end
      if (load) begin
        m_cnt = 0; m_pos = 0; m_ext = 0; m_shr = 0; m_used = 0;
      end else if (e_tick) begin
        m_cnt = 0;
        if (e_hard) begin m_pos = 1; m_ext = 0; m_shr = 0; m_used = 1; end
        else if (e_txp) begin m_pos = 0; m_ext = 0; m_shr = 0; m_used = 0; end
        else begin
          m_pos++;
          if (e_late) begin m_ext += e_adj; m_used = 1; end
          if (e_early) begin m_shr = e_sjw; m_used = 1; end
        end
      end else m_cnt++;
      if (guard) m_sw = 0; else if (sw_wr) m_sw = sw_wd;
      if (load) begin a_brp = s_brp; a_sjw = s_sjw; a_t1 = s_t1; a_t2 = s_t2; a_tri = s_tri; end
      if (wr) begin
        if (!cfg_sel) begin s_brp = int'(cfg_d[5:0]); s_sjw = int'(cfg_d[7:6]); end
        else begin s_t1 = int'(cfg_d[3:0]); s_t2 = int'(cfg_d[6:4]); s_tri = cfg_d[7]; end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    #5;
    cyc++;
    if (rst_n) begin
      model_eval();
      chk("R2 tick", int'(tick), int'(e_tick));
      chk("R4 R10 R11 R13 sample", int'(sample), int'(e_sample));
      chk("R3 R5 R12 R13 tx_point", int'(txp), int'(e_txp));
      chk("R4 R6 rx_bit", int'(rx_bit), int'(m_rxbit));
      chk("R7 R8 R9 swinit", int'(swinit), int'(m_sw));
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d expected below %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic cfg_write(logic sel, logic [7:0] d);
    @(negedge clk); cfg_wr = 1; cfg_sel = sel; cfg_d = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic sw_write(logic v);
    @(negedge clk); sw_wr = 1; sw_wd = v;
    @(negedge clk); sw_wr = 0;
  endtask

  task automatic measure(string req, int exp);
    int n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #5;
      if (txp) break;
    end
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #5;
      n++;
      if (txp) break;
    end
    chk(req, n, exp);
  endtask

  task automatic random_run(int cycles, int idle_len);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 6) == 0) rx = ~rx;
      if (i % idle_len == 0) idle = ~idle;
    end
    @(negedge clk); rx = 1; idle = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk("R1 swinit", int'(swinit), 1);
    chk("R1 sample", int'(sample), 0);
    chk("R1 tx_point", int'(txp), 0);
    chk("R1 rx_bit", int'(rx_bit), 1);
    @(negedge clk); rst_n = 1;
    measure("R1 R3 default period", 8);

    // prescaler 3, jump 2, T1 6, T2 4
    cfg_write(0, 8'h42);
    cfg_write(1, 8'h35);
    sw_write(0);
    chk("R8 swinit cleared", int'(swinit), 0);
    measure("R2 R3 R8 period", 33);

    // ignored writes: swinit low, then bus-off
    cfg_write(1, 8'h77);
    sw_write(1);
    bus_off = 1;
    cfg_write(0, 8'h00);
    bus_off = 0;
    sw_write(0);
    measure("R7 period after ignored writes", 33);

    random_run(3000, 250);

    // prescaler 1, jump 4, T1 16, T2 8, triple sampling
    sw_write(1);
    cfg_write(0, 8'hC0);
    cfg_write(1, 8'hFF);
    sw_write(0);
    measure("R3 max segments", 25);
    random_run(4000, 300);

    // guard: both segment fields zero
    sw_write(1);
    cfg_write(1, 8'h80);
    repeat (2) @(negedge clk);
    #5;
    chk("R9 guard cleared swinit", int'(swinit), 0);
    measure("R9 no copy on guard", 25);

    // set swinit and write in the cycle the guard fires
    @(negedge clk); sw_wr = 1; sw_wd = 1;
    @(negedge clk); sw_wr = 0; cfg_wr = 1; cfg_sel = 1; cfg_d = 8'h10;
    @(negedge clk); cfg_wr = 0;
    #5;
    chk("R9 guard swinit low", int'(swinit), 0);
    sw_write(1);
    cfg_write(0, 8'h41);
    sw_write(0);
    measure("R3 R9 zero field minimum", 10);
    random_run(3000, 200);

    repeat (20) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule